// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a simple single-word host request port to one rank of SDR SDRAM organised as four banks, each holding 4096 rows of 256 sixteen-bit words. It drives the chip-select, row-strobe, column-strobe and write-enable lines, the two bank-select bits and the twelve-bit multiplexed address bus, and it owns the data-bus output enable.

After reset the controller brings the memory up on its own. It waits out a settle period, closes every bank, runs two refresh cycles and programs the mode register. Only then does it accept host traffic. Each accepted request becomes an ACTIVE to open the row, followed by a READ or WRITE that carries the column and asks the memory to close the row when the access completes. Read data is taken from the bus after the programmed CAS latency. A refresh timer raises a request at a fixed interval. That request is served as soon as the access in flight has finished, and it blocks new host requests until the REFRESH has been issued.

The host holds `req_valid` together with its address, direction and write data until it sees `req_ready` high at a clock edge. One word moves per request. Read results come back on `rd_valid` and `rd_data`.

Top module: `sdram_seq_ctrl`

## Requirements
- R1: While reset is held, the command lines carry NOP, and `req_ready`, `rd_valid` and `mem_dq_oe` are all low.
- R2: After reset the controller issues only NOPs for at least T_INIT cycles. It then issues a PRECHARGE with address bit 10 set (all banks), two REFRESH commands and a LOAD MODE with bank bits 0 and address value CAS_LAT*16. In that mode word, burst length field bits 2:0 are 0 (one word), bit 3 is 0 (sequential) and all other bits are 0. `req_ready` stays low until all of these have been issued.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} use these codes: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, LOAD MODE 0000.
- R4: The host word address splits as column = bits 7:0, bank = bits 9:8 and row = bits 21:10. ACTIVE carries the bank and the row. READ and WRITE carry the bank, the column on address bits 7:0 and address bit 10 set, which requests auto-precharge.
- R5: The controller enforces these minimum gaps before a later command: ACTIVE to READ/WRITE at least T_RCD cycles; after PRECHARGE T_RP; after REFRESH T_RFC; after LOAD MODE T_MRD; after READ CAS_LAT+T_RP; after WRITE T_WR+T_RP.
- R6: Write data appears on `mem_dq_out` with `mem_dq_oe` high in exactly the cycle that WRITE is on the command lines. `mem_dq_oe` is low in every other cycle.
- R7: `mem_dq_in` is sampled in the cycle CAS_LAT cycles after READ was on the command lines. The sampled word is presented on `rd_data` with `rd_valid` high for the one following cycle.
- R8: Once initialisation is complete, successive REFRESH commands are no more than REF_INTERVAL cycles apart plus the length of one access.
- R9: A refresh becomes due REF_INTERVAL cycles after the previous REFRESH. From that point `req_ready` is low, and the next command issued from idle is REFRESH, ahead of any waiting host request.
- R10: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. Its ACTIVE is on the command lines in the very next cycle, and each accepted request produces exactly one READ or WRITE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Host word address {row, bank, column} |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller can accept a request this edge |
| rd_valid | output | 1 | One-cycle strobe: `rd_data` holds a read result |
| rd_data | output | 16 | Read result |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | 2 | Bank select |
| mem_addr | output | 12 | Multiplexed row/column/mode address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Output enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
The bench's memory model drives a distinct junk word on `mem_dq_in` in every cycle except the one that falls CAS latency after a READ. A capture one cycle early or late therefore returns junk rather than the stored word. It runs idle stretches and back-to-back requests against a short refresh interval. A controller that let host traffic starve refresh, or that took a request while a refresh was due, would show a `req_ready` window or a REFRESH gap beyond the allowed bound. Every command is timed against the previous commands, so an ACTIVE-to-column, refresh-recovery or precharge gap that is one cycle too short is reported. The power-up order, including the exact mode word, is checked one command at a time.

// File: rtl/sdr_ctrl_pkg.sv
// Package: shared command codes, controller states and small helpers.
// Assumes active-low command lines ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_ctrl_pkg;

    // Command codes on {cs_n, ras_n, cas_n, we_n} (R3)
    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_NOP = 4'b0111
    } sdr_cmd_e;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_INIT_PRE,
        ST_INIT_REF_A,
        ST_INIT_REF_B,
        ST_INIT_LMR,
        ST_IDLE,
        ST_ACCESS
    } sdr_state_e;

    // Larger of two unsigned values, used to size counters
    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_addr_map.sv
// Module: splits a host word address into column, bank and row fields.
// Assumes the layout {row, bank, column} with column in the low bits.
module sdr_addr_map #(
    parameter int unsigned ROW_W  = 12,
    parameter int unsigned COL_W  = 8,
    parameter int unsigned BANK_W = 2,
    localparam int unsigned HADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic [HADDR_W-1:0] haddr_i,
    output logic [COL_W-1:0]   col_o,
    output logic [BANK_W-1:0]  bank_o,
    output logic [ROW_W-1:0]   row_o
);

    // Field extraction (R4)
    always_comb begin
        col_o  = haddr_i[COL_W-1:0];
        bank_o = haddr_i[COL_W +: BANK_W];
        row_o  = haddr_i[COL_W + BANK_W +: ROW_W];
    end

endmodule

// File: rtl/sdr_refresh_timer.sv
// Module: raises a refresh request REF_INTERVAL cycles after the last
// acknowledged refresh and holds it until acknowledged.
// Assumes ack_i is high in the cycle the REFRESH command is launched.
module sdr_refresh_timer #(
    parameter int unsigned REF_INTERVAL = 3800,
    localparam int unsigned CW = $clog2(REF_INTERVAL + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);

    logic [CW-1:0] cnt_q;

    // Interval counter and sticky request flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
        end else if (ack_i) begin
            cnt_q  <= '0;
            pend_o <= 1'b0;
        end else begin
            if (cnt_q == CW'(REF_INTERVAL - 1)) begin
                pend_o <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !ack_i) |=> pend_o);   // R8

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ack_i |=> !pend_o);   // R9

endmodule

// File: rtl/sdr_rd_capture.sv
// Module: tracks READ commands on the bus and samples the data bus
// CAS_LAT cycles later, then presents it for one cycle.
// Assumes CAS_LAT is 2 or 3 and rd_issue_i is the READ on the pins.
module sdr_rd_capture #(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned CAS_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic              rd_valid_o,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [CAS_LAT-1:0] lat_q;

    // Latency pipeline: one bit per cycle since READ
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= {lat_q[CAS_LAT-2:0], rd_issue_i};
        end
    end

    // Data capture when the pipeline bit reaches the latency
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_data_o  <= '0;
        end else begin
            rd_valid_o <= lat_q[CAS_LAT-1];
            if (lat_q[CAS_LAT-1]) begin
                rd_data_o <= dq_i;
            end
        end
    end

    AST_RD_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_issue_i, CAS_LAT + 1));   // R7

endmodule

// File: rtl/sdram_seq_ctrl.sv
// Module: SDRAM command sequencer. Runs power-up initialisation, turns
// each host request into ACTIVE + READ/WRITE with auto-precharge,
// inserts refresh when due, and returns read data after CAS latency.
// Assumes one access in flight, timing parameters >= 1 clock,
// CAS_LAT of 2 or 3, and COL_W < AP_BIT < ROW_W.
module sdram_seq_ctrl #(
    parameter int unsigned DATA_W       = 16,
    parameter int unsigned ROW_W        = 12,
    parameter int unsigned COL_W        = 8,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned AP_BIT       = 10,
    parameter int unsigned CAS_LAT      = 3,
    parameter int unsigned T_INIT       = 25000,
    parameter int unsigned T_RP         = 3,
    parameter int unsigned T_RCD        = 3,
    parameter int unsigned T_RFC        = 16,
    parameter int unsigned T_MRD        = 2,
    parameter int unsigned T_WR         = 2,
    parameter int unsigned REF_INTERVAL = 3800,
    localparam int unsigned HADDR_W = ROW_W + BANK_W + COL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [HADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ready,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mem_cs_n,
    output logic               mem_ras_n,
    output logic               mem_cas_n,
    output logic               mem_we_n,
    output logic [BANK_W-1:0]  mem_ba,
    output logic [ROW_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);
    import sdr_ctrl_pkg::*;

    localparam int unsigned RD_HOLD  = CAS_LAT + T_RP;
    localparam int unsigned WR_HOLD  = T_WR + T_RP;
    localparam int unsigned WAIT_MAX = max_u(max_u(max_u(T_INIT, RD_HOLD), max_u(WR_HOLD, T_RFC)),
                                             max_u(T_RCD, max_u(T_RP, T_MRD)));
    localparam int unsigned WCW      = $clog2(WAIT_MAX + 1);
    localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1) << AP_BIT;
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT) << 4;

    sdr_state_e          state_q, ret_q;
    logic [WCW-1:0]      wait_q;
    sdr_cmd_e            cmd_q;
    logic [BANK_W-1:0]   ba_q;
    logic [ROW_W-1:0]    addr_q;
    logic [DATA_W-1:0]   dq_q;
    logic                oe_q;
    logic                init_done_q;
    logic                write_q;
    logic [BANK_W-1:0]   bank_q;
    logic [COL_W-1:0]    col_q;
    logic [DATA_W-1:0]   wdata_q;

    logic [COL_W-1:0]    map_col;
    logic [BANK_W-1:0]   map_bank;
    logic [ROW_W-1:0]    map_row;
    logic                ref_pend;
    logic                ref_ack;

    sdr_addr_map #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BANK_W(BANK_W)
    ) addr_map_i (
        .haddr_i(req_addr),
        .col_o  (map_col),
        .bank_o (map_bank),
        .row_o  (map_row)
    );

    sdr_refresh_timer #(
        .REF_INTERVAL(REF_INTERVAL)
    ) ref_timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .ack_i (ref_ack),
        .pend_o(ref_pend)
    );

    sdr_rd_capture #(
        .DATA_W (DATA_W),
        .CAS_LAT(CAS_LAT)
    ) rd_cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_issue_i(cmd_q == CMD_RD),
        .dq_i      (mem_dq_in),
        .rd_valid_o(rd_valid),
        .rd_data_o (rd_data)
    );

    // Refresh acknowledge: high when a REFRESH is being launched this edge
    always_comb begin
        ref_ack = (state_q == ST_INIT_REF_A) || (state_q == ST_INIT_REF_B) ||
                  ((state_q == ST_IDLE) && ref_pend);
    end

    // Host may hand over a request only when idle and no refresh is due
    always_comb begin
        req_ready = (state_q == ST_IDLE) && !ref_pend;
    end

    // Command sequencer: one command per launch, then a timed wait
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_WAIT;
            ret_q       <= ST_INIT_PRE;
            wait_q      <= WCW'(T_INIT - 1);
            cmd_q       <= CMD_NOP;
            ba_q        <= '0;
            addr_q      <= '0;
            dq_q        <= '0;
            oe_q        <= 1'b0;
            init_done_q <= 1'b0;
            write_q     <= 1'b0;
            bank_q      <= '0;
            col_q       <= '0;
            wdata_q     <= '0;
        end else begin
            cmd_q <= CMD_NOP;
            oe_q  <= 1'b0;
            case (state_q)
                ST_WAIT: begin
                    if (wait_q == '0) begin
                        state_q <= ret_q;
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                ST_INIT_PRE: begin
                    cmd_q   <= CMD_PRE;
                    addr_q  <= AP_MASK;
                    wait_q  <= WCW'(T_RP - 1);
                    ret_q   <= ST_INIT_REF_A;
                    state_q <= ST_WAIT;
                end
                ST_INIT_REF_A: begin
                    cmd_q   <= CMD_REF;
                    wait_q  <= WCW'(T_RFC - 1);
                    ret_q   <= ST_INIT_REF_B;
                    state_q <= ST_WAIT;
                end
                ST_INIT_REF_B: begin
                    cmd_q   <= CMD_REF;
                    wait_q  <= WCW'(T_RFC - 1);
                    ret_q   <= ST_INIT_LMR;
                    state_q <= ST_WAIT;
                end
                ST_INIT_LMR: begin
                    cmd_q       <= CMD_LMR;
                    ba_q        <= '0;
                    addr_q      <= MODE_WORD;
                    init_done_q <= 1'b1;
                    wait_q      <= WCW'(T_MRD - 1);
                    ret_q       <= ST_IDLE;
                    state_q     <= ST_WAIT;
                end
                ST_IDLE: begin
                    if (ref_pend) begin
                        cmd_q   <= CMD_REF;
                        wait_q  <= WCW'(T_RFC - 1);
                        ret_q   <= ST_IDLE;
                        state_q <= ST_WAIT;
                    end else if (req_valid) begin
                        cmd_q   <= CMD_ACT;
                        ba_q    <= map_bank;
                        addr_q  <= map_row;
                        bank_q  <= map_bank;
                        col_q   <= map_col;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        wait_q  <= WCW'(T_RCD - 1);
                        ret_q   <= ST_ACCESS;
                        state_q <= ST_WAIT;
                    end
                end
                ST_ACCESS: begin
                    ba_q    <= bank_q;
                    addr_q  <= ROW_W'(col_q) | AP_MASK;
                    ret_q   <= ST_IDLE;
                    state_q <= ST_WAIT;
                    if (write_q) begin
                        cmd_q  <= CMD_WR;
                        dq_q   <= wdata_q;
                        oe_q   <= 1'b1;
                        wait_q <= WCW'(WR_HOLD - 1);
                    end else begin
                        cmd_q  <= CMD_RD;
                        wait_q <= WCW'(RD_HOLD - 1);
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Pin mapping of the registered command and data
    always_comb begin
        {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;
        mem_ba     = ba_q;
        mem_addr   = addr_q;
        mem_dq_out = dq_q;
        mem_dq_oe  = oe_q;
    end

    // Checker state: cycles since the last ACTIVE on the pins, saturating
    localparam int unsigned GAP_W = $clog2(T_RCD + 2);
    logic [GAP_W-1:0] act_gap_q;

    // Track distance from ACTIVE for the row-to-column check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_gap_q <= '0;
        end else if (cmd_q == CMD_ACT) begin
            act_gap_q <= GAP_W'(1);
        end else if (act_gap_q != GAP_W'(T_RCD)) begin
            act_gap_q <= act_gap_q + 1'b1;
        end
    end

    AST_INIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done_q |-> !req_ready);   // R2

    AST_RW_AUTO_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> mem_addr[AP_BIT]);   // R4

    AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> (act_gap_q >= GAP_W'(T_RCD)));   // R5

    AST_OE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (cmd_q == CMD_WR));   // R6

    AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ref_pend) |=> (cmd_q == CMD_REF));   // R9

    AST_ACCEPT_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_q == CMD_ACT));   // R10

endmodule

// File: tb/sdram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench: drives a request plan (directed corners then seeded random),
// models the memory, and times every command against the requirements.
module sdram_seq_ctrl_tb_top;

    localparam int CL   = 3;
    localparam int TI   = 50;
    localparam int TRP  = 3;
    localparam int TRCD = 2;
    localparam int TRFC = 7;
    localparam int TMRD = 2;
    localparam int TWR  = 2;
    localparam int RI   = 150;
    localparam int SLACK = 20;

    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                           C_LMR = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_write = 1'b0;
    logic [21:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic req_ready, rd_valid;
    logic [15:0] rd_data;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [1:0] mem_ba;
    logic [11:0] mem_addr;
    logic [15:0] mem_dq_out;
    logic mem_dq_oe;
    logic [15:0] mem_dq_in = '0;

    always #2 clk = ~clk;

    sdram_seq_ctrl #(
        .CAS_LAT(CL), .T_INIT(TI), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
        .T_MRD(TMRD), .T_WR(TWR), .REF_INTERVAL(RI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // Memory model contents and default pattern for unwritten words
    logic [15:0] mem_m [int];
    function automatic logic [15:0] dflt(input logic [21:0] a);
        return 16'(a[21:10] * 7 + a[7:0] * 3 + a[9:8] * 11) ^ 16'h5A5A;
    endfunction
    function automatic logic [15:0] model_rd(input logic [21:0] a);
        if (mem_m.exists(int'(a))) return mem_m[int'(a)];
        return dflt(a);
    endfunction

    // Request plan
    logic [21:0] p_addr[$];
    bit          p_wr[$];
    logic [15:0] p_wd[$];
    int          p_gap[$];

    task automatic plan(input logic [21:0] a, input bit w, input logic [15:0] d, input int g);
        p_addr.push_back(a); p_wr.push_back(w); p_wd.push_back(d); p_gap.push_back(g);
    endtask

    // Monitor / model / driver state
    int cyc = 0;
    int rst_cnt = 0;
    int last_act = -100000, last_ref = -100000, last_pre = -100000;
    int last_mrs = -100000, last_rd = -100000, last_wr = -100000;
    bit open_v[4];
    logic [11:0] open_r[4];
    int init_step = 0;
    int init_end = 0;
    int refs_after = 0;
    int rd_exp_cyc = -1;
    logic [15:0] rd_exp_data = '0;
    int drv_cyc = -1;
    logic [15:0] drv_data = '0;
    bit exp_v = 1'b0;
    logic [21:0] exp_addr = '0;
    bit exp_w = 1'b0;
    logic [15:0] exp_wd = '0;
    int acc_cyc = 0;
    bit acc_flag = 1'b0;
    int gap_left = 0;
    int tail = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            if (rst_cnt > 0) begin
                chk({mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} == C_NOP, "R1", "cmd in reset",
                    {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n}, C_NOP);
                chk(!req_ready && !rd_valid && !mem_dq_oe, "R1", "ready/valid/oe in reset",
                    {req_ready, rd_valid, mem_dq_oe}, 0);
            end
            rst_cnt++;
        end else if (!done) begin
            logic [3:0] cmd;
            logic [21:0] pa;
            cyc++;
            cmd = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

            // Read return timing and data (R7)
            if (rd_valid) begin
                chk(cyc == rd_exp_cyc, "R7", "rd_valid cycle", cyc, rd_exp_cyc);
                chk(rd_data == rd_exp_data, "R7", "rd_data", rd_data, rd_exp_data);
            end else if (cyc == rd_exp_cyc) begin
                chk(1'b0, "R7", "missing rd_valid", 0, 1);
            end

            if (mem_dq_oe && cmd != C_WR) chk(1'b0, "R6", "oe outside WRITE", cmd, C_WR);

            if (req_ready && init_step < 4) chk(1'b0, "R2", "ready before init", init_step, 4);
            if (req_ready && (cyc - last_ref) >= RI)
                chk(1'b0, "R9", "ready while refresh due", cyc - last_ref, RI - 1);

            if (cmd != C_NOP) begin
                chk(cmd inside {C_ACT, C_RD, C_WR, C_PRE, C_REF, C_LMR}, "R3", "legal code", cmd, C_NOP);
                chk((cyc - last_ref) >= TRFC, "R5", "after REFRESH", cyc - last_ref, TRFC);
                chk((cyc - last_pre) >= TRP, "R5", "after PRECHARGE", cyc - last_pre, TRP);
                chk((cyc - last_mrs) >= TMRD, "R5", "after LOAD MODE", cyc - last_mrs, TMRD);
                chk((cyc - last_rd) >= CL + TRP, "R5", "after READ", cyc - last_rd, CL + TRP);
                chk((cyc - last_wr) >= TWR + TRP, "R5", "after WRITE", cyc - last_wr, TWR + TRP);
            end

            case (cmd)
                C_PRE: begin
                    chk(init_step == 0 && mem_addr[10], "R2", "PRECHARGE all first", init_step, 0);
                    chk(cyc >= TI, "R2", "settle period", cyc, TI);
                    init_step = 1;
                    last_pre = cyc;
                end
                C_REF: begin
                    if (init_step >= 4) begin
                        chk((cyc - last_ref) <= RI + SLACK, "R8", "refresh gap", cyc - last_ref, RI + SLACK);
                        refs_after++;
                    end else begin
                        chk(init_step == 1 || init_step == 2, "R2", "init refresh order", init_step, 1);
                        init_step++;
                    end
                    chk(!open_v[0] && !open_v[1] && !open_v[2] && !open_v[3], "R9",
                        "refresh with row open", {open_v[3], open_v[2], open_v[1], open_v[0]}, 0);
                    last_ref = cyc;
                end
                C_LMR: begin
                    chk(init_step == 3, "R2", "LOAD MODE order", init_step, 3);
                    chk(mem_addr == 12'(CL * 16) && mem_ba == 2'd0, "R2", "mode word",
                        {mem_ba, mem_addr}, CL * 16);
                    init_step = 4;
                    init_end = cyc;
                    last_mrs = cyc;
                end
                C_ACT: begin
                    chk(init_step == 4, "R2", "ACTIVE before init done", init_step, 4);
                    chk(exp_v && cyc == acc_cyc + 1, "R10", "ACTIVE follows accept", cyc, acc_cyc + 1);
                    chk(mem_ba == exp_addr[9:8], "R4", "ACTIVE bank", mem_ba, exp_addr[9:8]);
                    chk(mem_addr == exp_addr[21:10], "R4", "ACTIVE row", mem_addr, exp_addr[21:10]);
                    open_v[mem_ba] = 1'b1;
                    open_r[mem_ba] = mem_addr;
                    last_act = cyc;
                end
                C_RD, C_WR: begin
                    chk(open_v[mem_ba], "R5", "column cmd with row open", open_v[mem_ba], 1);
                    chk((cyc - last_act) >= TRCD, "R5", "ACTIVE to column", cyc - last_act, TRCD);
                    chk(mem_addr[10], "R4", "auto-precharge bit", mem_addr[10], 1);
                    chk(exp_v && (cmd == C_WR) == exp_w, "R10", "direction", cmd, exp_w ? C_WR : C_RD);
                    chk(mem_ba == exp_addr[9:8] && mem_addr[7:0] == exp_addr[7:0], "R4",
                        "bank/column", {mem_ba, mem_addr[7:0]}, exp_addr[9:0]);
                    pa = {open_r[mem_ba], mem_ba, mem_addr[7:0]};
                    if (cmd == C_WR) begin
                        chk(mem_dq_oe && mem_dq_out == exp_wd, "R6", "write data",
                            {mem_dq_oe, mem_dq_out}, {1'b1, exp_wd});
                        mem_m[int'(pa)] = mem_dq_out;
                        last_wr = cyc;
                    end else begin
                        drv_cyc = cyc + CL;
                        drv_data = model_rd(pa);
                        rd_exp_cyc = cyc + CL + 1;
                        rd_exp_data = model_rd(exp_addr);
                        last_rd = cyc;
                    end
                    open_v[mem_ba] = 1'b0;
                    exp_v = 1'b0;
                end
                default: ;
            endcase

            // Memory data bus: junk except in the CAS-latency cycle
            mem_dq_in = (cyc == drv_cyc) ? drv_data : (16'hBAD0 ^ 16'(cyc));

            // Request driver
            if (acc_flag) begin
                acc_flag = 1'b0;
                req_valid = 1'b0;
            end
            if (!req_valid) begin
                if (gap_left > 0) begin
                    gap_left--;
                end else if (p_addr.size() > 0) begin
                    req_valid = 1'b1;
                    req_addr = p_addr.pop_front();
                    req_write = p_wr.pop_front();
                    req_wdata = p_wd.pop_front();
                    gap_left = p_gap.pop_front();
                end
            end
            if (req_valid && req_ready) begin
                acc_flag = 1'b1;
                chk(!exp_v, "R10", "one access per request", exp_v, 0);
                exp_v = 1'b1;
                exp_addr = req_addr;
                exp_w = req_write;
                exp_wd = req_wdata;
                acc_cyc = cyc;
            end

            if (p_addr.size() == 0 && !req_valid && !exp_v && gap_left == 0) tail++;
            if (tail == 400) done = 1'b1;
            if (cyc > 60000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                done = 1'b1;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        plan(22'h000000, 1'b1, 16'hA5A5, 0);
        plan(22'h000000, 1'b0, 16'h0000, 0);
        plan(22'h3FFFFF, 1'b1, 16'h1234, 0);
        plan(22'h3FFFFF, 1'b0, 16'h0000, 0);
        plan({12'd5, 2'd1, 8'd7}, 1'b1, 16'hC0DE, 0);
        plan({12'd6, 2'd1, 8'd7}, 1'b0, 16'h0000, 0);
        plan({12'd5, 2'd1, 8'd7}, 1'b0, 16'h0000, 200);
        plan({12'd4095, 2'd3, 8'd255}, 1'b0, 16'h0000, 0);
        for (int i = 0; i < 300; i++) begin
            logic [21:0] a;
            int g;
            a = {12'($urandom % 3), 2'($urandom), 8'($urandom % 4)};
            g = (($urandom % 40) == 0) ? 200 : int'($urandom % 4);
            plan(a, 1'($urandom), 16'($urandom), g);
        end
        repeat (6) @(posedge clk);
        #1 rst_n = 1'b1;
        wait (done);
        chk(init_step == 4, "R2", "init completed", init_step, 4);
        chk(refs_after >= (cyc - init_end) / (RI + SLACK), "R8", "refresh count",
            refs_after, (cyc - init_end) / (RI + SLACK));
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule